// File: doc/BRIEF.md
# Asynchronous Word-Memory Read Controller

This block sits on the host side of a parallel bus to an asynchronous one-time-programmable memory of 262,144 words of 16 bits. It takes a read request with an 18-bit word address and returns the 16-bit word with a single-cycle valid pulse. It drives the address, an active-low chip-select strobe and an active-low output-enable strobe, and it samples the data bus at a fixed point.

The memory's limits are given in nanoseconds: address-to-data, select-to-data, enable-to-data and the time the data bus keeps floating after release. Parameters turn these into clock-cycle counts, so the same RTL serves the 55 ns grade and the 90 ns grade. The output enable is not raised together with the chip select. It is held back for as long as the late-enable slack allows, so that its own short access path ends on the same clock as the address path. After each read both strobes stay high for the float interval before another access may start. A request that arrives in that interval waits.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `rd_ready` is 1, `mem_ce_n` and `mem_oe_n` are 1 and `rd_valid` is 0.
- R2: A request is accepted on a rising edge where `rd_req` and `rd_ready` are both 1. From that edge `mem_addr` carries the request address and `mem_ce_n` is 0. `rd_ready` stays 0 until the controller is idle again.
- R3: `mem_oe_n` falls OE_DLY edges after the accepting edge, where OE_DLY = ACC_CYC − OE_CYC. `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R4: The data bus is sampled on the edge ACC_CYC+1 edges after the accepting edge. From that edge `rd_valid` is 1 for exactly one cycle, and `rd_data` holds the word stored at the requested address.
- R5: Both strobes return to 1 on the sampling edge, not earlier. `mem_addr` does not change while `mem_ce_n` is 0.
- R6: After release the strobes stay high for DF_CYC cycles, after which `rd_ready` returns to 1. A request held during that interval is accepted only then, so `mem_ce_n` is high for at least DF_CYC+1 cycles between accesses and never falls less than the float time after the last release.
- R7: Every cycle count is the smallest whole number of clock periods that covers the nanosecond limit, and it is at least 1. ACC_CYC is the largest of the address count, the select count, and the enable count plus 1. OE_CYC is the enable count, and DF_CYC is the float count.
- R8: With the period at 10 ns, the fast parameter set (55/55/20/20 ns) gives a read latency of 7 cycles and the slow set (90/90/35/20 ns) gives 10 cycles, both from the same RTL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request, held until accepted |
| rd_addr | input | 18 | Word address of the request |
| rd_ready | output | 1 | Controller idle, a request is taken on this edge |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` valid |
| rd_data | output | 16 | Word read from memory |
| mem_addr | output | 18 | Address to the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | input | 16 | Data bus from the memory |

## Verification
Isolated reads at address 0 and at the top address show the base strobe timeline with quiet gaps around it. Back-to-back requests held high through the float interval tell an early re-select apart from a correct wait. The alternating-bit addresses 0x2AAAA and 0x15555 reveal swapped or stuck address and data lines. The memory model returns unknown data until each of its three access paths has elapsed, so a sampling point one cycle early, or an output enable raised too late, shows up as a data mismatch. Both speed grades run the same sequence.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR_CE,
    S_WAIT_OE,
    S_WAIT_DATA,
    S_CAPTURE,
    S_FLOAT
  } rd_state_e;

  // whole clock periods covering a nanosecond limit, never below one
  function automatic int ns_to_cyc(input int ns, input int per);
    if (ns <= per) return 1;
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // edges from select to the sampling point (sampling happens one edge later)
  function automatic int access_cyc(input int t_addr, input int t_ce,
                                    input int t_oe, input int per);
    return imax(imax(ns_to_cyc(t_addr, per), ns_to_cyc(t_ce, per)),
                ns_to_cyc(t_oe, per) + 1);
  endfunction

  // enable is held back so its path ends with the address path
  function automatic int oe_delay(input int acc, input int t_oe, input int per);
    return acc - ns_to_cyc(t_oe, per);
  endfunction

endpackage

// File: rtl/eprom_rd_seq.sv
`timescale 1ns/1ps
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int ACC_CYC = 6,
  parameter int OE_DLY  = 4,
  parameter int DF_CYC  = 2,
  parameter int CNT_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ready,
  output logic accept_evt,
  output logic cap_evt,
  output logic ce_n,
  output logic oe_n
);

  localparam logic [CNT_W-1:0] OE_LAST  = CNT_W'(OE_DLY - 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] DF_LAST  = CNT_W'(DF_CYC - 1);

  rd_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready      = (st_q == S_IDLE);
  assign accept_evt = ready && req;
  assign cap_evt    = (st_q == S_CAPTURE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (req) begin
            st_q  <= S_ADDR_CE;
            cnt_q <= '0;
            ce_n  <= 1'b0;
          end
        end
        S_ADDR_CE: begin
          cnt_q <= cnt_q + 1'b1;
          if (OE_DLY == 1) begin
            oe_n <= 1'b0;
            st_q <= S_WAIT_DATA;
          end else begin
            st_q <= S_WAIT_OE;
          end
        end
        S_WAIT_OE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == OE_LAST) begin
            oe_n <= 1'b0;
            st_q <= S_WAIT_DATA;
          end
        end
        S_WAIT_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == ACC_LAST) st_q <= S_CAPTURE;
        end
        S_CAPTURE: begin
          ce_n  <= 1'b1;
          oe_n  <= 1'b1;
          cnt_q <= '0;
          st_q  <= S_FLOAT;
        end
        S_FLOAT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == DF_LAST) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && oe_n)); // R6

endmodule

// File: rtl/eprom_rd_cap.sv
`timescale 1ns/1ps
module eprom_rd_cap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] data,
  output logic              valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= cap_evt;
      if (cap_evt) data <= dq;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R4

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 10,
  parameter int T_ADDR_NS  = 55,
  parameter int T_CE_NS    = 55,
  parameter int T_OE_NS    = 20,
  parameter int T_FLOAT_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq
);

  localparam int ACC_CYC = access_cyc(T_ADDR_NS, T_CE_NS, T_OE_NS, CLK_NS);
  localparam int OE_CYC  = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int OE_DLY  = oe_delay(ACC_CYC, T_OE_NS, CLK_NS);
  localparam int DF_CYC  = ns_to_cyc(T_FLOAT_NS, CLK_NS);
  localparam int CNT_W   = $clog2(ACC_CYC + DF_CYC + 4);

  logic accept_evt;
  logic cap_evt;
  logic [ADDR_W-1:0] addr_q;

  eprom_rd_seq #(
    .ACC_CYC(ACC_CYC), .OE_DLY(OE_DLY), .DF_CYC(DF_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .ready(rd_ready),
    .accept_evt(accept_evt), .cap_evt(cap_evt),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n)
  );

  eprom_rd_cap #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .dq(mem_dq),
    .data(rd_data), .valid(rd_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (accept_evt) addr_q <= rd_addr;
  end
  assign mem_addr = addr_q;

  // strobe run-length counters, observed by the assertions only
  localparam logic [CNT_W-1:0] SAT = '1;
  logic [CNT_W-1:0] ce_lo_cnt, oe_lo_cnt, ce_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_lo_cnt <= '0;
      oe_lo_cnt <= '0;
      ce_hi_cnt <= SAT;
    end else begin
      ce_lo_cnt <= mem_ce_n ? '0 : ((ce_lo_cnt == SAT) ? SAT : ce_lo_cnt + 1'b1);
      oe_lo_cnt <= mem_oe_n ? '0 : ((oe_lo_cnt == SAT) ? SAT : oe_lo_cnt + 1'b1);
      ce_hi_cnt <= !mem_ce_n ? '0 : ((ce_hi_cnt == SAT) ? SAT : ce_hi_cnt + 1'b1);
    end
  end

  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n); // R3

  AST_OE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (oe_lo_cnt == CNT_W'(OE_CYC))); // R3

  AST_CAPTURE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (ce_lo_cnt == CNT_W'(ACC_CYC))); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R5

  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (ce_hi_cnt >= CNT_W'(DF_CYC + 1))); // R6

endmodule

// File: tb/sim_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_lane #(
  parameter int    TA   = 55,
  parameter int    TC   = 55,
  parameter int    TO   = 20,
  parameter int    TD   = 20,
  parameter int    PER  = 10,
  parameter int    EXP_LAT = 7,
  parameter string NAME = "fast"
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_cmp,
  output int   n_bad
);

  // expected counts, found by stepping up one period at a time (R7)
  function automatic int up_cyc(input int ns);
    int n;
    n = 1;
    while (n * PER < ns) n++;
    return n;
  endfunction
  localparam int ACC_E  = (up_cyc(TA) > up_cyc(TC) ? up_cyc(TA) : up_cyc(TC)) > up_cyc(TO) + 1 ?
                          (up_cyc(TA) > up_cyc(TC) ? up_cyc(TA) : up_cyc(TC)) : up_cyc(TO) + 1;
  localparam int ODLY_E = ACC_E - up_cyc(TO);
  localparam int DF_E   = up_cyc(TD);

  function automatic logic [15:0] word_at(input logic [17:0] a);
    return (a[15:0] * 16'd40503) ^ {14'd0, a[17:16]} ^ 16'h5A5A;
  endfunction

  logic        rd_req;
  logic [17:0] rd_addr;
  logic        rd_ready, rd_valid, mem_ce_n, mem_oe_n;
  logic [15:0] rd_data, mem_dq;
  logic [17:0] mem_addr;

  eprom_rd_ctrl #(
    .CLK_NS(PER), .T_ADDR_NS(TA), .T_CE_NS(TC), .T_OE_NS(TO), .T_FLOAT_NS(TD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_dq(mem_dq)
  );

  // bus-functional memory: unknown data until every access path has elapsed
  time t_addr, t_ce, t_oe, t_rel;
  int  ovl;
  initial begin
    t_addr = 0; t_ce = 0; t_oe = 0; t_rel = 0; ovl = 0; mem_dq = 'z;
  end
  always @(mem_addr) t_addr = $time;
  always @(negedge mem_oe_n) t_oe = $time;
  always @(negedge mem_ce_n) begin
    if ($time - t_rel < TD) ovl++;
    t_ce = $time;
  end
  always @(posedge mem_ce_n or posedge mem_oe_n) t_rel = $time;
  always @(negedge clk) begin
    if (mem_ce_n !== 1'b0 || mem_oe_n !== 1'b0) mem_dq = 'z;
    else if (($time - t_addr) >= TA && ($time - t_ce) >= TC && ($time - t_oe) >= TO)
      mem_dq = word_at(mem_addr);
    else mem_dq = 'x;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s at %0t: got %h expected %h", NAME, tag, $time, act, exp);
    end
  endtask

  // behavioural reference: edge count since acceptance
  bit          busy;
  int          t;
  logic [17:0] qaddr;
  initial begin busy = 0; t = 0; qaddr = '0; n_cmp = 0; n_bad = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      busy = 0;
    end else if (busy) begin
      t++;
      if (t == ACC_E + 1 + DF_E) busy = 0;
    end else if (rd_req) begin
      busy = 1; t = 0; qaddr = rd_addr;
    end
  end

  always @(negedge clk) begin
    logic e_ce, e_oe, e_val;
    e_ce  = !(busy && t <= ACC_E);
    e_oe  = !(busy && t >= ODLY_E && t <= ACC_E);
    e_val = busy && (t == ACC_E + 1);
    if (!rst_n) begin
      chk("R1 ready in reset", 32'(rd_ready), 32'd1);
      chk("R1 ce_n in reset", 32'(mem_ce_n), 32'd1);
      chk("R1 oe_n in reset", 32'(mem_oe_n), 32'd1);
      chk("R1 valid in reset", 32'(rd_valid), 32'd0);
    end else begin
      chk("R2 R6 ready", 32'(rd_ready), 32'(!busy));
      chk("R2 R5 ce_n", 32'(mem_ce_n), 32'(e_ce));
      chk("R3 oe_n", 32'(mem_oe_n), 32'(e_oe));
      chk("R4 R7 R8 valid", 32'(rd_valid), 32'(e_val));
      if (!e_ce) chk("R2 R5 address", 32'(mem_addr), 32'(qaddr));
      if (e_val) chk("R4 data", 32'(rd_data), 32'(word_at(qaddr)));
    end
  end

  task automatic issue(input logic [17:0] a);
    rd_req = 1'b1; rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rest(input int n);
    rd_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    done = 1'b0; rd_req = 1'b0; rd_addr = '0;
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk("R8 latency", 32'(ACC_E + 1), 32'(EXP_LAT));
    issue(18'h00000); rest(16);
    issue(18'h3FFFF); rest(16);
    issue(18'h2AAAA); issue(18'h15555); issue(18'h00001); issue(18'h3FFFE); // R6 held through float
    rest(20);
    issue(18'h12345); rest(3);
    issue(18'h0F0F0); rest(20);
    chk("R6 float gap", 32'(ovl), 32'd0);
    done = 1'b1;
  end

endmodule

module sim_eprom_rd_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done_f, done_s;
  int   cmp_f, bad_f, cmp_s, bad_s;
  int   wd_bad = 0;

  always #5 clk = ~clk;

  sim_lane #(.TA(55), .TC(55), .TO(20), .TD(20), .PER(10), .EXP_LAT(7),  .NAME("fast")) l_fast (
    .clk(clk), .rst_n(rst_n), .done(done_f), .n_cmp(cmp_f), .n_bad(bad_f));
  sim_lane #(.TA(90), .TC(90), .TO(35), .TD(20), .PER(10), .EXP_LAT(10), .NAME("slow")) l_slow (
    .clk(clk), .rst_n(rst_n), .done(done_s), .n_cmp(cmp_s), .n_bad(bad_s));

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!(done_f === 1'b1 && done_s === 1'b1) && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (cycles >= 20000) begin
      wd_bad = 1;
      $display("FAIL watchdog: run hung, got done=%b%b expected 11", done_f, done_s);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             cmp_f + cmp_s + wd_bad, bad_f + bad_s + wd_bad);
    $finish;
  end
endmodule